// File: doc/BRIEF.md
# Register-Driven Serial EEPROM Emulator

This block stands in for a small serial EEPROM that software drives by repeated 32-bit writes to one control register. Software sets and clears a serial-clock bit in that register. Each write that takes the clock bit from 0 to 1 counts as one clock pulse. On each pulse the block reads the data-in bit. From these bits it builds a command byte and, for a read, a word address. It then returns the addressed 16-bit word one bit at a time on a data-out bit of the same register.

The stored image is 64 words of 16 bits. It is loaded at reset with a fixed pattern: word 0 holds 0xBABA and every other word is zero. The register also carries an access request bit. Any write copies that bit straight into a grant bit. Protocol faults set a sticky error output. A fault abandons the command in progress, and the next command is accepted normally.

Top module: `serial_eeprom_emu`

## Requirements
- R1: After reset, rd_data reads 0x0000_2010 (write-enable field bits 5:4 = 1, device-type bit 13 = 1, all else 0) and err is 0.
- R2: rd_data returns the last written value of bits 0, 1, 2, 4, 5, 6, 8, 9, 10 and 13. Every other bit reads 0, except bit 3 (data out) and bit 7 (grant). Writes never set bit 3 directly.
- R3: A protocol step happens only on a write with bit 0 = 1 while the stored bit 0 is 0. Any other write leaves bit 3 and the protocol position unchanged.
- R4: The first 8 steps of a command shift bit 2 into an opcode, MSB first. With opcode 0x03, the next 8 steps shift in a word address, MSB first.
- R5: After a 0x03 command and its address, the next 16 steps set bit 3 to bit n of the addressed word on data step n, starting at n = 0. Word 0 is 0xBABA after reset and words 1 to 63 are 0.
- R6: With opcode 0x05, the next 8 steps each drive bit 3 to 0.
- R7: When a command's last data step is done, the next step starts a new opcode. Back-to-back commands work without any other action.
- R8: Every write sets bit 7 of rd_data equal to bit 6 of the written value.
- R9: If 8 opcode bits form a value other than 0x03 or 0x05, err goes to 1 and stays 1 until reset. The command is dropped, and the following step begins a new opcode.
- R10: A read address of 64 or more sets err, and all 16 data steps drive bit 3 to 0.
- R11: Bit 1 (chip select) is stored and read back but has no effect on the protocol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full 32-bit register write strobe |
| wr_data | input | 32 | Value written to the register |
| rd_data | output | 32 | Current register view, including the data-out bit |
| err | output | 1 | Sticky protocol error flag |

## Verification
The hardest thing to prove from the ports is that a write carrying clock 1 while the stored clock is already 1 is not counted as a step. Such a write leaves nothing visible behind unless data out would have changed. The bench therefore places a repeated clock-high write with a different data-in bit in the middle of a read of 0xBABA, at a point where the next data bit differs from the current one. It checks that data out holds, and then that the remaining bits of the word still arrive in order. Error recovery is reached by issuing an unknown opcode followed at once by a valid read.

// File: rtl/sre_pkg.sv
package sre_pkg;
  localparam int REG_W   = 32;
  localparam int OPC_W   = 8;
  localparam int ADR_W   = 8;
  localparam logic [OPC_W-1:0] OP_READ = 8'h03;
  localparam logic [OPC_W-1:0] OP_STAT = 8'h05;
  localparam int STAT_BITS = 8;

  // register field positions (software-visible layout)
  localparam int B_SK   = 0;
  localparam int B_CS   = 1;
  localparam int B_DIN  = 2;
  localparam int B_DOUT = 3;
  localparam int B_FWE  = 4;   // two bits
  localparam int B_REQ  = 6;
  localparam int B_GNT  = 7;
  localparam int B_PRES = 8;
  localparam int B_SIZE = 9;   // two bits
  localparam int B_TYPE = 13;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_ADR  = 2'd1,
    PH_RDAT = 2'd2,
    PH_STAT = 2'd3
  } phase_t;

  // reset image of the storage array
  function automatic logic [15:0] image_word(input int idx);
    return (idx == 0) ? 16'hBABA : 16'h0000;
  endfunction

  // MSB-first serial shift
  function automatic logic [7:0] shift_msb(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction
endpackage

// File: rtl/sre_ctl_reg.sv
module sre_ctl_reg
  import sre_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             dout_i,
  output logic [REG_W-1:0] rd_data,
  output logic             step_o,
  output logic             din_o
);
  logic       sk_q, cs_q, din_q, req_q, gnt_q, pres_q, type_q;
  logic [1:0] fwe_q, size_q;

  logic unused_ok;
  assign unused_ok = ^{wr_data[31:14], wr_data[12:11], wr_data[B_DOUT], wr_data[B_GNT]};

  // rising serial clock seen across two writes
  assign step_o = wr_en && !sk_q && wr_data[B_SK];
  assign din_o  = wr_data[B_DIN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_q   <= 1'b0;
      cs_q   <= 1'b0;
      din_q  <= 1'b0;
      req_q  <= 1'b0;
      gnt_q  <= 1'b0;
      pres_q <= 1'b0;
      type_q <= 1'b1;
      fwe_q  <= 2'd1;
      size_q <= 2'd0;
    end else if (wr_en) begin
      sk_q   <= wr_data[B_SK];
      cs_q   <= wr_data[B_CS];
      din_q  <= wr_data[B_DIN];
      req_q  <= wr_data[B_REQ];
      gnt_q  <= wr_data[B_REQ];
      pres_q <= wr_data[B_PRES];
      type_q <= wr_data[B_TYPE];
      fwe_q  <= wr_data[B_FWE+1:B_FWE];
      size_q <= wr_data[B_SIZE+1:B_SIZE];
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[B_SK]            = sk_q;
    rd_data[B_CS]            = cs_q;
    rd_data[B_DIN]           = din_q;
    rd_data[B_DOUT]          = dout_i;
    rd_data[B_FWE+1:B_FWE]   = fwe_q;
    rd_data[B_REQ]           = req_q;
    rd_data[B_GNT]           = gnt_q;
    rd_data[B_PRES]          = pres_q;
    rd_data[B_SIZE+1:B_SIZE] = size_q;
    rd_data[B_TYPE]          = type_q;
  end
endmodule

// File: rtl/sre_rom.sv
module sre_rom
  import sre_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  // image is loaded at reset and held; no write commands exist
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= WORD_W'(image_word(i));
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_q[i];
    end
  end

  assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/sre_proto.sv
module sre_proto
  import sre_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              din,
  input  logic [WORD_W-1:0] rom_word,
  output logic [AW-1:0]     rom_addr,
  output logic              dout,
  output logic              err,
  output phase_t            phase,
  output logic              opc_done,
  output logic              bad_opc,
  output logic              cmd_done,
  output logic              addr_oob
);
  logic [OPC_W-1:0] opc_q;
  logic [ADR_W-1:0] adr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OPC_W-1:0] opc_nx;
  logic             last8, last16;

  assign opc_nx   = shift_msb(opc_q, din);
  assign last8    = (cnt_q == CNT_W'(OPC_W-1));
  assign last16   = (cnt_q == CNT_W'(WORD_W-1));
  assign rom_addr = adr_q[AW-1:0];
  assign addr_oob = (adr_q >= ADR_W'(DEPTH));

  assign opc_done = step && (phase == PH_OPC) && last8;
  assign bad_opc  = opc_done && (opc_nx != OP_READ) && (opc_nx != OP_STAT);
  assign cmd_done = step && (((phase == PH_RDAT) && last16) ||
                             ((phase == PH_STAT) && (cnt_q == CNT_W'(STAT_BITS-1))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_OPC;
      opc_q <= '0;
      adr_q <= '0;
      cnt_q <= '0;
      dout  <= 1'b0;
      err   <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (phase)
        PH_OPC: begin
          opc_q <= opc_nx;
          if (last8) begin
            cnt_q <= '0;
            opc_q <= '0;
            if (opc_nx == OP_READ)      phase <= PH_ADR;
            else if (opc_nx == OP_STAT) phase <= PH_STAT;
            else begin
              phase <= PH_OPC;
              err   <= 1'b1;
            end
          end
        end
        PH_ADR: begin
          adr_q <= shift_msb(adr_q, din);
          if (last8) begin
            cnt_q <= '0;
            phase <= PH_RDAT;
          end
        end
        PH_RDAT: begin
          dout <= addr_oob ? 1'b0 : rom_word[cnt_q];
          if (addr_oob) err <= 1'b1;
          if (last16) begin
            cnt_q <= '0;
            adr_q <= '0;
            phase <= PH_OPC;
          end
        end
        PH_STAT: begin
          dout <= 1'b0;
          if (cnt_q == CNT_W'(STAT_BITS-1)) begin
            cnt_q <= '0;
            phase <= PH_OPC;
          end
        end
        default: phase <= PH_OPC;
      endcase
    end
  end
endmodule

// File: rtl/serial_eeprom_emu.sv
module serial_eeprom_emu
  import sre_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        err
);
  localparam int AW = $clog2(DEPTH);

  logic              step, din, dout;
  logic [AW-1:0]     rom_addr;
  logic [WORD_W-1:0] rom_word;
  phase_t            phase;
  logic              opc_done, bad_opc, cmd_done, addr_oob;

  sre_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dout_i(dout), .rd_data(rd_data), .step_o(step), .din_o(din)
  );

  sre_rom #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .rd_addr(rom_addr), .rd_word(rom_word)
  );

  sre_proto #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .step(step), .din(din),
    .rom_word(rom_word), .rom_addr(rom_addr), .dout(dout), .err(err),
    .phase(phase), .opc_done(opc_done), .bad_opc(bad_opc),
    .cmd_done(cmd_done), .addr_oob(addr_oob)
  );
endmodule

// File: rtl/serial_eeprom_emu_chk.sv
module serial_eeprom_emu_chk
  import sre_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        err,
  input logic        step,
  input logic        bad_opc,
  input logic        cmd_done,
  input phase_t      phase
);
  logic unused_ok;
  assign unused_ok = ^{wr_data[31:7], wr_data[5:1], rd_data[31:8], rd_data[6:4],
                       rd_data[2:1], cmd_done};

  // R8: grant mirrors the request bit of the last write
  p_grant_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[B_GNT] == $past(wr_data[B_REQ])));

  // R3: without a 0->1 clock write, data out holds
  p_no_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !rd_data[B_SK] && wr_data[B_SK]) |=> $stable(rd_data[B_DOUT]));

  // R6: status steps drive zero
  p_status_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_STAT) |=> !rd_data[B_DOUT]);

  // R9: an unknown opcode raises the flag and returns to opcode collection
  p_bad_opc_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opc |=> (err && phase == PH_OPC));

  // R9: the flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind serial_eeprom_emu serial_eeprom_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .err(err), .step(step), .bad_opc(bad_opc),
  .cmd_done(cmd_done), .phase(phase)
);

// File: tb/serial_eeprom_emu_tb_top.sv
module serial_eeprom_emu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] base = 32'h0000_2012;   // fwe=1, type=1, cs=1
  bit   exp_q[$];
  string tag_q[$];
  event samp_ev;

  always #2.5 clk = ~clk;   // 200 MHz

  serial_eeprom_emu dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .err(err)
  );

  function automatic logic [15:0] model_word(input int a);
    if (a == 0) return 16'hBABA;
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic b);
    wr(base | (32'(b) << 2));
    wr(base | (32'(b) << 2) | 32'h1);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) step(v[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // driver: read command, pushes expected bits; glitch_at inserts a repeated high clock
  task automatic read_cmd(input int a, input int glitch_at, input string req);
    logic [15:0] w;
    w = (a < 64) ? model_word(a) : 16'h0;
    send_byte(8'h03);
    send_byte(8'(a));
    for (int n = 0; n < 16; n++) begin
      step(1'b0);
      exp_q.push_back(w[n]);
      tag_q.push_back(req);
      -> samp_ev;
      #0;
      if (n == glitch_at) begin
        wr(base | 32'h5);   // clock already high: not a step (R3)
        check("R3 repeated high clock holds dout", 32'(rd_data[3]), 32'(w[n]));
        wr(base | 32'h4);   // clock low only
        check("R3 low write holds dout", 32'(rd_data[3]), 32'(w[n]));
      end
    end
  endtask

  task automatic stat_cmd();
    send_byte(8'h05);
    for (int n = 0; n < 8; n++) begin
      step(1'b1);
      exp_q.push_back(1'b0);
      tag_q.push_back("R6 status bit");
      -> samp_ev;
      #0;
    end
  endtask

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(samp_ev);
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard underflow actual=%b expected=none", rd_data[3]);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 32'(rd_data[3]), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset register", rd_data, 32'h0000_2010);
    check("R1 reset err", 32'(err), 32'h0);

    // R8 grant mirrors request
    wr(base | 32'h40);
    check("R8 grant set", 32'(rd_data[7]), 32'h1);
    wr(base);
    check("R8 grant cleared", 32'(rd_data[7]), 32'h0);

    // R4 R5: word 0, with repeated-high glitch at bit 2 (bit2=0, bit3=1)
    read_cmd(0, 2, "R5 word0 bit");
    // R7 back-to-back: status right after word0 (last bit 1)
    check("R5 last bit of word0", 32'(rd_data[3]), 32'h1);
    stat_cmd();
    // R5 other word zero, R7 next command
    read_cmd(5, -1, "R5 word5 bit");
    read_cmd(0, -1, "R7 word0 again");
    check("R9 no error on valid commands", 32'(err), 32'h0);

    // R11: chip select low, protocol still runs
    base = 32'h0000_2010;
    read_cmd(0, -1, "R11 cs low read");
    base = 32'h0000_2012;

    // R2 field readback; clock already high so not a step
    wr(32'h0000_0001 | base);
    wr(32'hFFFF_FFFF);
    check("R2 all-ones readback", rd_data, 32'h0000_27F7 | (32'(rd_data[3]) << 3));
    check("R2 dout not writable", 32'(rd_data[3]), 32'h1);
    wr(32'h0000_0000);
    check("R2 zero readback", rd_data, 32'h0000_0008);
    wr(base);

    // R9 bad opcode then recovery
    send_byte(8'h07);
    check("R9 bad opcode err", 32'(err), 32'h1);
    read_cmd(0, -1, "R9 read after abort");
    check("R9 err sticky", 32'(err), 32'h1);

    // R10 address out of range after fresh reset
    do_reset();
    check("R1 err cleared by reset", 32'(err), 32'h0);
    read_cmd(70, -1, "R10 oob bit");
    check("R10 oob err", 32'(err), 32'h1);

    @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule